// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a 9-bit first-in first-out buffer with separate write and read clocks. The clocks may be unrelated or tied together. Its depth is a power-of-two parameter. A word is pushed when the first write enable is low and the second write enable is high. A word is popped when both read enables are low. The popped word appears on a registered, three-state data output.

Four active-low status outputs report the fill level. Empty and almost-empty are computed and updated only in the read clock domain. Full and almost-full are computed and updated only in the write clock domain. Each pointer reaches the opposite domain as a Gray code through a two-flop synchronizer.

The second write enable has a second job. When it is held low, write cycles load two threshold registers: the almost-empty offset n and the almost-full offset m. Read cycles then return these registers on the data output instead of popping. The same pin therefore switches the port between data traffic and threshold programming.

Top module: `pflag_fifo`

## Requirements
- R1: On a rising write-clock edge with `wen1_ni` low, `wen2_ld_i` high and the FIFO not full, `wdata_i` is stored. Words leave in the order in which they were stored.
- R2: On a rising read-clock edge with `ren1_ni` and `ren2_ni` both low, `wen2_ld_i` high and the FIFO not empty, the oldest word is removed. That word is on `rdata_o` after the edge. With no pop, `rdata_o` keeps its value.
- R3: A push attempted while full is ignored. It neither overwrites data nor moves the write pointer.
- R4: A pop attempted while empty is ignored. `rdata_o` holds, and the read pointer does not move.
- R5: During and after reset, `empty_no` and `aempty_no` are low, and `full_no` and `afull_no` are high. The offsets reset to n = 7 and m = 7.
- R6: `empty_no` is low exactly when the read domain sees zero stored words. `full_no` is low exactly when the write domain sees DEPTH stored words. A change made by the other clock shows within four cycles of the observing clock.
- R7: `aempty_no` is low when the stored count is n or less.
- R8: `afull_no` is low when the stored count is DEPTH − m or more.
- R9: A write-clock edge with `wen1_ni` low and `wen2_ld_i` low loads `wdata_i` into the offset word selected by an internal selector, and pushes nothing. The order is the n words first, then the m words. The selector wraps after the last word. The flags use the low log2(DEPTH) bits of each offset.
- R10: A read-clock edge with both read enables low and `wen2_ld_i` low places the selected offset word on `rdata_o`. The order is the same as for loading, and the selector wraps. Nothing is popped.
- R11: When log2(DEPTH) exceeds 9, each offset takes two words, low 9 bits first. The load order is n-low, n-high, m-low, m-high, and then it wraps.
- R12: While `oe_ni` is high, `rdata_o` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen1_ni | input | 1 | Write enable, active low |
| wen2_ld_i | input | 1 | Write enable (high) / offset access select (low) |
| wdata_i | input | 9 | Write data or offset word |
| ren1_ni | input | 1 | Read enable 1, active low |
| ren2_ni | input | 1 | Read enable 2, active low |
| oe_ni | input | 1 | Output enable, active low |
| rdata_o | output | 9 | Read data or offset word, three-state |
| empty_no | output | 1 | Empty, active low, read domain |
| aempty_no | output | 1 | Almost empty, active low, read domain |
| full_no | output | 1 | Full, active low, write domain |
| afull_no | output | 1 | Almost full, active low, write domain |

## Verification
A corrupted pointer or a broken Gray crossing makes the flags disagree with the count that the bench tracks. This shows at the next flag sample, which comes four cycles after each push or pop. The same fault also changes the data order at the next pop. A push or pop that leaks through in a full, empty, load or readback cycle leaves the pointers off by one. The bench sees this at the next flag sample, or when draining fails to reach empty. A threshold word stored under the wrong selector value shows up at once as a wrong readback value, and as almost flags that switch at the wrong level.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  typedef enum logic [1:0] {
    WOP_IDLE,
    WOP_PUSH,
    WOP_LOAD,
    WOP_BLOCKED
  } wr_op_e;

  typedef enum logic [1:0] {
    ROP_IDLE,
    ROP_POP,
    ROP_PEEK,
    ROP_STALL
  } rd_op_e;
endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pff_wr_ctrl.sv
module pff_wr_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 256,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1,
  localparam int PARTS  = (ADDR_W + DATA_W - 1) / DATA_W,
  localparam int NWORD  = 2 * PARTS,
  localparam int OREG_W = PARTS * DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wen1_ni,
  input  logic                    wen2_ld_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [PTR_W-1:0]        rgray_i,
  output logic                    we_o,
  output logic [ADDR_W-1:0]       waddr_o,
  output logic [PTR_W-1:0]        wgray_o,
  output logic [ADDR_W-1:0]       ae_ofs_o,
  output logic [NWORD*DATA_W-1:0] ofs_words_o,
  output logic                    full_no,
  output logic                    afull_no
);
  localparam int SEL_W = $clog2(NWORD);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  wr_op_e            op;
  logic [PTR_W-1:0]  wbin_q, wbin_nxt, wgray_q, rbin, wcount;
  logic [OREG_W-1:0] ae_q, af_q;
  logic [SEL_W-1:0]  sel_q;
  logic              full, afull;

  always_comb begin
    rbin[PTR_W-1] = rgray_i[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_i[i];
  end

  assign wcount = wbin_q - rbin;
  assign full   = (wcount == DEPTH_P);
  assign afull  = (wcount >= (DEPTH_P - {1'b0, af_q[ADDR_W-1:0]}));

  always_comb begin
    op = WOP_IDLE;
    if (!wen1_ni) begin
      if (!wen2_ld_i) op = WOP_LOAD;
      else if (full)  op = WOP_BLOCKED;
      else            op = WOP_PUSH;
    end
  end

  assign wbin_nxt = wbin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ae_q    <= OREG_W'(AE_DEF);
      af_q    <= OREG_W'(AF_DEF);
      sel_q   <= '0;
    end else begin
      case (op)
        WOP_PUSH: begin
          wbin_q  <= wbin_nxt;
          wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
        end
        WOP_LOAD: begin
          for (int p = 0; p < PARTS; p++) begin
            if (sel_q == SEL_W'(p))         ae_q[p*DATA_W +: DATA_W] <= wdata_i;
            if (sel_q == SEL_W'(p + PARTS)) af_q[p*DATA_W +: DATA_W] <= wdata_i;
          end
          sel_q <= (sel_q == SEL_W'(NWORD - 1)) ? '0 : sel_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign we_o        = (op == WOP_PUSH);
  assign waddr_o     = wbin_q[ADDR_W-1:0];
  assign wgray_o     = wgray_q;
  assign ae_ofs_o    = ae_q[ADDR_W-1:0];
  assign ofs_words_o = {af_q, ae_q};
  assign full_no     = ~full;
  assign afull_no    = ~afull;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcount <= DEPTH_P); // R3
  AST_FULL_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wen1_ni && wen2_ld_i && !full_no) |=> $stable(wbin_q)); // R3
  AST_LOAD_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wen1_ni && !wen2_ld_i) |=> $stable(wbin_q)); // R9
  AST_WGRAY_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R6
  AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no); // R8
endmodule

// File: rtl/pff_rd_ctrl.sv
module pff_rd_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1,
  localparam int PARTS  = (ADDR_W + DATA_W - 1) / DATA_W,
  localparam int NWORD  = 2 * PARTS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ren1_ni,
  input  logic                    ren2_ni,
  input  logic                    ld_ni,
  input  logic [PTR_W-1:0]        wgray_i,
  input  logic [ADDR_W-1:0]       ae_ofs_i,
  input  logic [NWORD*DATA_W-1:0] ofs_words_i,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic [ADDR_W-1:0]       raddr_o,
  output logic [PTR_W-1:0]        rgray_o,
  output logic [DATA_W-1:0]       q_o,
  output logic                    empty_no,
  output logic                    aempty_no
);
  localparam int SEL_W = $clog2(NWORD);

  rd_op_e            op;
  logic [PTR_W-1:0]  rbin_q, rbin_nxt, rgray_q, wbin, rcount;
  logic [DATA_W-1:0] q_q;
  logic [SEL_W-1:0]  sel_q;
  logic              empty, aempty;

  always_comb begin
    wbin[PTR_W-1] = wgray_i[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_i[i];
  end

  assign rcount = wbin - rbin_q;
  assign empty  = (rcount == '0);
  assign aempty = (rcount <= {1'b0, ae_ofs_i});

  always_comb begin
    op = ROP_IDLE;
    if (!ren1_ni && !ren2_ni) begin
      if (!ld_ni)     op = ROP_PEEK;
      else if (empty) op = ROP_STALL;
      else            op = ROP_POP;
    end
  end

  assign rbin_nxt = rbin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
      sel_q   <= '0;
    end else begin
      case (op)
        ROP_POP: begin
          rbin_q  <= rbin_nxt;
          rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
          q_q     <= mem_rdata_i;
        end
        ROP_PEEK: begin
          q_q   <= ofs_words_i[sel_q*DATA_W +: DATA_W];
          sel_q <= (sel_q == SEL_W'(NWORD - 1)) ? '0 : sel_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign raddr_o   = rbin_q[ADDR_W-1:0];
  assign rgray_o   = rgray_q;
  assign q_o       = q_q;
  assign empty_no  = ~empty;
  assign aempty_no = ~aempty;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ren1_ni && !ren2_ni && ld_ni && !empty_no) |=> ($stable(rbin_q) && $stable(q_q))); // R4
  AST_PEEK_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ren1_ni && !ren2_ni && !ld_ni) |=> $stable(rbin_q)); // R10
  AST_RGRAY_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1); // R6
  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no); // R7
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 256,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen1_ni,
  input  logic              wen2_ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              aempty_no,
  output logic              full_no,
  output logic              afull_no
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int PARTS  = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int NWORD  = 2 * PARTS;

  logic                    we;
  logic [ADDR_W-1:0]       waddr, raddr, ae_ofs;
  logic [PTR_W-1:0]        wgray, rgray, wgray_rs, rgray_ws;
  logic [NWORD*DATA_W-1:0] ofs_words;
  logic [DATA_W-1:0]       mem_rdata, q;

  pff_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen1_ni(wen1_ni), .wen2_ld_i(wen2_ld_i),
    .wdata_i(wdata_i), .rgray_i(rgray_ws), .we_o(we), .waddr_o(waddr),
    .wgray_o(wgray), .ae_ofs_o(ae_ofs), .ofs_words_o(ofs_words),
    .full_no(full_no), .afull_no(afull_no)
  );

  pff_sync #(.W(PTR_W)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  pff_sync #(.W(PTR_W)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  pff_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  pff_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni),
    .ld_ni(wen2_ld_i), .wgray_i(wgray_rs), .ae_ofs_i(ae_ofs),
    .ofs_words_i(ofs_words), .mem_rdata_i(mem_rdata), .raddr_o(raddr),
    .rgray_o(rgray), .q_o(q), .empty_no(empty_no), .aempty_no(aempty_no)
  );

  assign rdata_o = oe_ni ? {DATA_W{1'bz}} : q;
endmodule

// File: tb/pflag_fifo_bench.sv
`timescale 1ns/1ps
module pflag_fifo_bench;
  localparam int DA = 16;
  localparam int DB = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  // small instance
  logic       a_wen1_n = 1'b1, a_wen2 = 1'b1, a_ren1_n = 1'b1, a_ren2_n = 1'b1, a_oe_n = 1'b0;
  logic [8:0] a_wdata = '0;
  wire  [8:0] a_rdata;
  logic       a_empty_n, a_aempty_n, a_full_n, a_afull_n;

  for (genvar i = 0; i < 9; i++) begin : g_pu
    pullup (a_rdata[i]);
  end

  pflag_fifo #(.DEPTH(DA)) u_pflag_fifo (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .wen1_ni(a_wen1_n), .wen2_ld_i(a_wen2),
    .wdata_i(a_wdata), .ren1_ni(a_ren1_n), .ren2_ni(a_ren2_n), .oe_ni(a_oe_n),
    .rdata_o(a_rdata), .empty_no(a_empty_n), .aempty_no(a_aempty_n),
    .full_no(a_full_n), .afull_no(a_afull_n)
  );

  // deep instance: two-word offsets
  logic       b_wen1_n = 1'b1, b_wen2 = 1'b1, b_ren1_n = 1'b1, b_ren2_n = 1'b1;
  logic [8:0] b_wdata = '0;
  wire  [8:0] b_rdata;
  logic       b_empty_n, b_aempty_n, b_full_n, b_afull_n;

  pflag_fifo #(.DEPTH(DB)) u_pflag_fifo_wide (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .wen1_ni(b_wen1_n), .wen2_ld_i(b_wen2),
    .wdata_i(b_wdata), .ren1_ni(b_ren1_n), .ren2_ni(b_ren2_n), .oe_ni(1'b0),
    .rdata_o(b_rdata), .empty_no(b_empty_n), .aempty_no(b_aempty_n),
    .full_no(b_full_n), .afull_no(b_afull_n)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] wa(input int k);
    return 9'((k * 37 + 5) & 511);
  endfunction

  function automatic logic [8:0] wb(input int k);
    return 9'((k * 11 + 200) & 511);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic a_push(input logic [8:0] d);
    a_wen1_n = 1'b0; a_wen2 = 1'b1; a_wdata = d;
    @(negedge clk);
    a_wen1_n = 1'b1;
  endtask

  task automatic a_load(input logic [8:0] d);
    a_wen1_n = 1'b0; a_wen2 = 1'b0; a_wdata = d;
    @(negedge clk);
    a_wen1_n = 1'b1; a_wen2 = 1'b1;
  endtask

  task automatic a_pop();
    a_ren1_n = 1'b0; a_ren2_n = 1'b0;
    @(negedge clk);
    a_ren1_n = 1'b1; a_ren2_n = 1'b1;
  endtask

  task automatic a_peek();
    a_wen2 = 1'b0; a_ren1_n = 1'b0; a_ren2_n = 1'b0;
    @(negedge clk);
    a_wen2 = 1'b1; a_ren1_n = 1'b1; a_ren2_n = 1'b1;
  endtask

  task automatic a_flags(input int lvl, input int n, input int m);
    chk("R6 empty", {8'd0, a_empty_n}, {8'd0, !(lvl == 0)});
    chk("R6 full", {8'd0, a_full_n}, {8'd0, !(lvl == DA)});
    chk("R7 aempty", {8'd0, a_aempty_n}, {8'd0, !(lvl <= n)});
    chk("R8 afull", {8'd0, a_afull_n}, {8'd0, !(lvl >= DA - m)});
  endtask

  task automatic b_op(input logic wen1_n, input logic wen2, input logic rd, input logic [8:0] d);
    b_wen1_n = wen1_n; b_wen2 = wen2; b_wdata = d;
    b_ren1_n = !rd; b_ren2_n = !rd;
    @(negedge clk);
    b_wen1_n = 1'b1; b_wen2 = 1'b1; b_ren1_n = 1'b1; b_ren2_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R5: flags during reset
    chk("R5 empty in reset", {8'd0, a_empty_n}, 9'd0);
    chk("R5 aempty in reset", {8'd0, a_aempty_n}, 9'd0);
    chk("R5 full in reset", {8'd0, a_full_n}, 9'd1);
    chk("R5 afull in reset", {8'd0, a_afull_n}, 9'd1);
    rst_n = 1'b1;
    idle(2);
    a_flags(0, 7, 7); // R5 defaults n=7 m=7

    // R1 R6 R7 R8: fill sweep with default offsets
    for (int k = 1; k <= DA; k++) begin
      a_push(wa(k - 1));
      idle(4);
      a_flags(k, 7, 7);
    end

    // R3: push while full
    a_push(9'h0AA);
    idle(4);
    chk("R3 still full", {8'd0, a_full_n}, 9'd0);

    // R2 drain sweep
    for (int k = 0; k < DA; k++) begin
      a_pop();
      chk("R2 pop data", a_rdata, wa(k));
      idle(4);
      a_flags(DA - 1 - k, 7, 7);
    end
    chk("R3 no extra word", {8'd0, a_empty_n}, 9'd0);

    // R4: pop while empty
    a_pop();
    chk("R4 rdata holds", a_rdata, wa(DA - 1));
    idle(4);
    a_push(9'h123);
    idle(4);
    a_pop();
    chk("R4 pointer intact", a_rdata, 9'h123);
    idle(4);
    chk("R4 empty again", {8'd0, a_empty_n}, 9'd0);

    // R9: load n=3, m=12
    a_load(9'd3);
    a_load(9'd12);
    idle(4);
    chk("R9 load pushes nothing", {8'd0, a_empty_n}, 9'd0);
    for (int k = 1; k <= DA; k++) begin
      a_push(wb(k - 1));
      idle(4);
      a_flags(k, 3, 12); // R9
    end

    // R10: readback order and wrap, no pop
    a_peek();
    chk("R10 readback n", a_rdata, 9'd3);
    a_peek();
    chk("R10 readback m", a_rdata, 9'd12);
    a_peek();
    chk("R10 readback wrap", a_rdata, 9'd3);
    idle(4);
    chk("R10 still full", {8'd0, a_full_n}, 9'd0);
    a_pop();
    chk("R10 first word kept", a_rdata, wb(0));

    // R12: output enable
    a_oe_n = 1'b1;
    #1;
    chk("R12 high impedance", a_rdata, 9'h1FF);
    a_oe_n = 1'b0;
    #1;
    chk("R12 drive restored", a_rdata, wb(0));

    for (int k = 1; k < DA; k++) begin
      a_pop();
      chk("R2 pop data 2", a_rdata, wb(k));
    end
    idle(4);
    a_flags(0, 3, 12);

    // R11: two-word offsets, n = 517, m = 32
    b_op(1'b0, 1'b0, 1'b0, 9'd5);
    b_op(1'b0, 1'b0, 1'b0, 9'd1);
    b_op(1'b0, 1'b0, 1'b0, 9'd32);
    b_op(1'b0, 1'b0, 1'b0, 9'd0);
    b_op(1'b1, 1'b0, 1'b1, 9'd0);
    chk("R11 rb n low", b_rdata, 9'd5);
    b_op(1'b1, 1'b0, 1'b1, 9'd0);
    chk("R11 rb n high", b_rdata, 9'd1);
    b_op(1'b1, 1'b0, 1'b1, 9'd0);
    chk("R11 rb m low", b_rdata, 9'd32);
    b_op(1'b1, 1'b0, 1'b1, 9'd0);
    chk("R11 rb m high", b_rdata, 9'd0);
    b_op(1'b1, 1'b0, 1'b1, 9'd0);
    chk("R11 rb wrap", b_rdata, 9'd5);
    for (int k = 0; k < 517; k++) b_op(1'b0, 1'b1, 1'b0, 9'(k));
    idle(4);
    chk("R11 aempty at 517", {8'd0, b_aempty_n}, 9'd0);
    b_op(1'b0, 1'b1, 1'b0, 9'd0);
    idle(4);
    chk("R11 aempty at 518", {8'd0, b_aempty_n}, 9'd1);
    for (int k = 518; k < 991; k++) b_op(1'b0, 1'b1, 1'b0, 9'd0);
    idle(4);
    chk("R11 afull at 991", {8'd0, b_afull_n}, 9'd1);
    b_op(1'b0, 1'b1, 1'b0, 9'd0);
    idle(4);
    chk("R11 afull at 992", {8'd0, b_afull_n}, 9'd0);
    chk("R11 not full at 992", {8'd0, b_full_n}, 9'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule